// File: doc/BRIEF.md
# Column-driver grayscale input latch

This block is the digital front end of a display column driver with a large number of output channels. Each channel holds a 6-bit grayscale code. On every shift clock a 36-bit bus delivers six codes, and a group sequencer writes them into the next six positions of a first-stage line register. The sequencer waits for a cascade enable and fills the whole line in 64 clocks. It then hands the enable on to the next driver in the chain with a one-clock pulse, so a row of drivers can share one data bus and take turns loading it.

A fill-direction input picks the channel order and the roles of the two cascade pins. In the forward order, channel 0 is filled first, pin A is the enable input and pin B is the enable output. In the reverse order all of these swap. A separate line-load strobe copies the complete first stage into a second-stage register in a single clock. The second stage drives the grayscale decoders and holds its value until the next strobe. The strobe also returns the sequencer to idle, so the next line starts only on a fresh enable.

Top module: `col_latch_top`

## Requirements
- R1: During and after reset, `line_o` is all zeros and both `en_a_o` and `en_b_o` are low. The sequencer is idle.
- R2: While idle, a clock edge that sees the selected enable input high (and `line_load` low) captures `data_i` into the first group. Each of the next 63 clock edges captures the next group. Enable inputs are ignored while a fill is in progress.
- R3: With `dir_rev`=0 the k-th captured group (k=0..63) goes to channels 6k..6k+5, with bus lane j (`data_i[6j+5:6j]`) going to channel 6k+j.
- R4: With `dir_rev`=1 lane j of the k-th captured group goes to channel 383-6k-j.
- R5: With `dir_rev`=0, `en_a_i` is the enable input and `en_b_o` the enable output. With `dir_rev`=1, `en_b_i` is the input and `en_a_o` the output. The unselected input has no effect, and the unselected output stays low.
- R6: The edge that captures the 64th group raises the selected enable output for exactly one clock. Afterwards the sequencer is idle and captures nothing until the enable input is seen again.
- R7: A clock edge with `line_load` high copies the first stage, as it stood before that edge, to `line_o`. Channel c occupies `line_o[6c+5:6c]`.
- R8: `line_o` does not change on any edge where `line_load` is low, whatever the first stage is doing.
- R9: On an edge where `line_load` is high, the strobe wins over the sequencer. No capture happens, the sequencer becomes idle, the enable inputs are ignored and no enable pulse follows, even if that edge would have captured the last group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rev | input | 1 | 0: forward fill, pin A in / pin B out; 1: reverse fill, pins swapped |
| en_a_i | input | 1 | Cascade enable input, pin A |
| en_b_i | input | 1 | Cascade enable input, pin B |
| en_a_o | output | 1 | Cascade enable output, pin A |
| en_b_o | output | 1 | Cascade enable output, pin B |
| data_i | input | 36 | Six 6-bit grayscale codes per clock |
| line_load | input | 1 | Line strobe: copy first stage to second stage |
| line_o | output | 2304 | Second-stage codes, 384 channels x 6 bits |

## Verification
The line strobe and a group capture can fall on the same edge. This includes the edge that would capture the last group and raise the cascade pulse. The bench provokes both cases by asserting `line_load` partway through a fill and again exactly on the 64th fill clock. A behavioural reference model, a queue of pending channel slots, is compared against `line_o` and both enable outputs after every edge. The check is that the copied line holds the pre-edge first stage, that no write or pulse leaks through, and that a later strobe shows the first stage unchanged by the dropped capture.

// File: rtl/col_latch_pkg.sv
package col_latch_pkg;

   // Source lane for output slot i of a group, given the fill direction.
   function automatic int unsigned lane_src(input int unsigned slot,
                                            input int unsigned per_clk,
                                            input bit rev);
      return rev ? (per_clk - 1 - slot) : slot;
   endfunction

   // Physical group written at fill position k.
   function automatic int unsigned phys_grp(input int unsigned k,
                                            input int unsigned groups,
                                            input bit rev);
      return rev ? (groups - 1 - k) : k;
   endfunction

endpackage

// File: rtl/col_latch_seq.sv
module col_latch_seq #(
   parameter int unsigned GROUPS = 64,
   localparam int unsigned GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_in,
   input  logic          load,
   output logic          wr_en,
   output logic [GW-1:0] wr_idx,
   output logic          done
);

   localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

   logic          busy_q;
   logic [GW-1:0] ptr_q;

   assign wr_en  = !load && (busy_q || en_in);
   assign wr_idx = busy_q ? ptr_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
         done   <= 1'b0;
      end else if (load) begin
         busy_q <= 1'b0;
         ptr_q  <= '0;
         done   <= 1'b0;
      end else if (busy_q) begin
         if (ptr_q == LAST) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
            done   <= 1'b1;
         end else begin
            ptr_q <= ptr_q + 1'b1;
            done  <= 1'b0;
         end
      end else if (en_in) begin
         busy_q <= 1'b1;
         ptr_q  <= GW'(1);
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/col_latch_stage1.sv
module col_latch_stage1
   import col_latch_pkg::*;
#(
   parameter int unsigned GROUPS  = 64,
   parameter int unsigned PER_CLK = 6,
   parameter int unsigned CODE_W  = 6,
   localparam int unsigned GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
   localparam int unsigned BUS_W  = PER_CLK * CODE_W,
   localparam int unsigned LINE_W = GROUPS * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GW-1:0]     wr_idx,
   input  logic              rev,
   input  logic [BUS_W-1:0]  data_i,
   output logic [LINE_W-1:0] s1_flat
);

   for (genvar p = 0; p < GROUPS; p++) begin : g_grp
      logic hit;
      assign hit = wr_en &&
         (wr_idx == (rev ? GW'(phys_grp(p, GROUPS, 1'b1)) : GW'(p)));

      for (genvar s = 0; s < PER_CLK; s++) begin : g_slot
         localparam int unsigned FWD = lane_src(s, PER_CLK, 1'b0);
         localparam int unsigned REV = lane_src(s, PER_CLK, 1'b1);
         localparam int unsigned CH  = p * PER_CLK + s;
         always_ff @(posedge clk) begin
            if (!rst_n)
               s1_flat[CH*CODE_W +: CODE_W] <= '0;
            else if (hit)
               s1_flat[CH*CODE_W +: CODE_W] <= rev ? data_i[REV*CODE_W +: CODE_W]
                                                   : data_i[FWD*CODE_W +: CODE_W];
         end
      end
   end

endmodule

// File: rtl/col_latch_stage2.sv
module col_latch_stage2 #(
   parameter int unsigned LINE_W = 2304
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LINE_W-1:0] d,
   output logic [LINE_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/col_latch_top.sv
module col_latch_top #(
   parameter int unsigned CHANNELS = 384,
   parameter int unsigned PER_CLK  = 6,
   parameter int unsigned CODE_W   = 6,
   localparam int unsigned GROUPS  = CHANNELS / PER_CLK,
   localparam int unsigned GW      = (GROUPS > 1) ? $clog2(GROUPS) : 1,
   localparam int unsigned BUS_W   = PER_CLK * CODE_W,
   localparam int unsigned LINE_W  = CHANNELS * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_rev,
   input  logic              en_a_i,
   input  logic              en_b_i,
   output logic              en_a_o,
   output logic              en_b_o,
   input  logic [BUS_W-1:0]  data_i,
   input  logic              line_load,
   output logic [LINE_W-1:0] line_o
);

   if (CHANNELS % PER_CLK != 0) begin : g_bad_div
      $error("CHANNELS must be a multiple of PER_CLK");
   end
   if (GROUPS < 2) begin : g_bad_groups
      $error("at least two groups per line are required");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("CODE_W must be nonzero");
   end

   logic              en_sel;
   logic              wr_en;
   logic [GW-1:0]     wr_idx;
   logic              done;
   logic [LINE_W-1:0] s1_flat;

   assign en_sel = dir_rev ? en_b_i : en_a_i;
   assign en_a_o = done &&  dir_rev;
   assign en_b_o = done && !dir_rev;

   col_latch_seq #(.GROUPS(GROUPS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_in  (en_sel),
      .load   (line_load),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .done   (done)
   );

   col_latch_stage1 #(
      .GROUPS  (GROUPS),
      .PER_CLK (PER_CLK),
      .CODE_W  (CODE_W)
   ) u_s1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .rev     (dir_rev),
      .data_i  (data_i),
      .s1_flat (s1_flat)
   );

   col_latch_stage2 #(.LINE_W(LINE_W)) u_s2 (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (line_load),
      .d     (s1_flat),
      .q     (line_o)
   );

endmodule

// File: rtl/col_latch_chk.sv
module col_latch_chk #(
   parameter int unsigned LINE_W = 2304
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dir_rev,
   input logic              line_load,
   input logic              en_a_o,
   input logic              en_b_o,
   input logic [LINE_W-1:0] s1_flat,
   input logic [LINE_W-1:0] line_o
);

   // R6: enable pulse lasts one clock
   p_pulse_one_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a_o || en_b_o) |=> !(en_a_o || en_b_o));

   // R5: only the output on the side chosen by the direction may pulse
   p_out_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_rev ? !en_b_o : !en_a_o));

   // R7: strobe copies the pre-edge first stage
   p_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_load |=> (line_o == $past(s1_flat)));

   // R8: second stage holds without a strobe
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !line_load |=> $stable(line_o));

   // R9: a strobe edge never yields an enable pulse
   p_load_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_load |=> !(en_a_o || en_b_o));

endmodule

bind col_latch_top col_latch_chk #(.LINE_W(CHANNELS * CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dir_rev   (dir_rev),
   .line_load (line_load),
   .en_a_o    (en_a_o),
   .en_b_o    (en_b_o),
   .s1_flat   (s1_flat),
   .line_o    (line_o)
);

// File: tb/col_latch_top_tb_top.sv
`timescale 1ns/1ps
module col_latch_top_tb_top;

   localparam int NCH = 384;
   localparam int PER = 6;
   localparam int CW  = 6;
   localparam int LW  = NCH * CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dir_rev = 1'b0;
   logic          en_a_i = 1'b0;
   logic          en_b_i = 1'b0;
   logic [35:0]   data_i = '0;
   logic          line_load = 1'b0;
   logic          en_a_o, en_b_o;
   logic [LW-1:0] line_o;

   int     n_vec = 0;
   int     n_bad = 0;
   string  tag = "R1";

   logic [LW-1:0] m_s1 = '0;
   logic [LW-1:0] m_s2 = '0;
   logic          m_pulse = 1'b0;
   int            slots[$];

   always #2.5 clk = ~clk;

   col_latch_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_rev   (dir_rev),
      .en_a_i    (en_a_i),
      .en_b_i    (en_b_i),
      .en_a_o    (en_a_o),
      .en_b_o    (en_b_o),
      .data_i    (data_i),
      .line_load (line_load),
      .line_o    (line_o)
   );

   // Reference model: a queue of channel slots still waiting to be written.
   always @(posedge clk) begin
      logic np;
      np = 1'b0;
      if (!rst_n) begin
         m_s1 = '0;
         m_s2 = '0;
         slots.delete();
      end else if (line_load) begin
         m_s2 = m_s1;
         slots.delete();
      end else begin
         if (slots.size() == 0 && (dir_rev ? en_b_i : en_a_i)) begin
            for (int c = 0; c < NCH; c++)
               slots.push_back(dir_rev ? NCH - 1 - c : c);
         end
         if (slots.size() > 0) begin
            for (int j = 0; j < PER; j++) begin
               int ch;
               ch = slots.pop_front();
               m_s1[ch*CW +: CW] = data_i[j*CW +: CW];
            end
            if (slots.size() == 0) np = 1'b1;
         end
      end
      m_pulse = np;
   end

   task automatic compare();
      logic ea, eb;
      ea = m_pulse && dir_rev;
      eb = m_pulse && !dir_rev;
      n_vec++;
      if (line_o !== m_s2) begin
         n_bad++;
         $display("FAIL %s line_o actual=%h expected=%h", tag, line_o, m_s2);
      end
      n_vec++;
      if (en_a_o !== ea || en_b_o !== eb) begin
         n_bad++;
         $display("FAIL %s enables actual a=%b b=%b expected a=%b b=%b",
                  tag, en_a_o, en_b_o, ea, eb);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   // Start a fill on the selected side and run n clocks of random data.
   task automatic fill(input logic rev, input int n, input int load_at);
      dir_rev = rev;
      for (int i = 0; i < n; i++) begin
         data_i = 36'({$urandom(), $urandom()});
         if (rev) begin en_b_i = (i == 0); en_a_i = 1'b1; end
         else     begin en_a_i = (i == 0); en_b_i = 1'b1; end
         if (i == 10) begin
            if (rev) en_b_i = 1'b1; else en_a_i = 1'b1;  // mid-fill enable, ignored (R2)
         end
         line_load = (i == load_at);
         tick();
      end
      en_a_i = 1'b0; en_b_i = 1'b0; line_load = 1'b0;
   endtask

   task automatic strobe();
      line_load = 1'b1;
      tick();
      line_load = 1'b0;
      tick();
   endtask

   initial begin
      // R1: reset state
      tag = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R2 R3 R6: forward fill, pulse on pin B, then idle
      tag = "R2 R3 R6";
      fill(1'b0, 70, -1);
      tag = "R7";
      strobe();

      // R5: the unselected input has no effect
      tag = "R5";
      dir_rev = 1'b0;
      en_b_i = 1'b1;
      repeat (5) begin data_i = 36'({$urandom(), $urandom()}); tick(); end
      en_b_i = 1'b0;
      strobe();

      // R4: reverse fill, pins swapped
      tag = "R4 R5 R6";
      fill(1'b1, 68, -1);
      tag = "R7";
      strobe();

      // R8: first-stage activity without strobe leaves line_o alone
      tag = "R8";
      fill(1'b0, 66, -1);
      tag = "R7";
      strobe();

      // R9: strobe partway through a fill
      tag = "R9";
      fill(1'b1, 40, 20);
      strobe();

      // R9: strobe exactly on the last-group edge
      tag = "R9";
      fill(1'b0, 66, 63);
      strobe();
      fill(1'b1, 66, 63);
      strobe();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule